// File: doc/BRIEF.md
# Fault-Gated Bus Request Port

This block sits on the path between a memory-requesting master (an instruction fetch port or a load/store port) and an external request/grant/response bus. A separate protection checker looks at the master's current address and raises a per-request fault flag. When that flag is high, the block keeps the request off the bus entirely. It then finishes the transaction toward the master on its own: a grant is produced locally, and a response carrying an error follows. To the master, a protection fault therefore looks like any other bus error and arrives in the same phase.

The fault flag is sampled into a register, and the locally produced grant comes from that registered copy. A faulted access therefore costs one extra cycle before its grant. The direction of the access (load or store) is captured when the transaction is granted, whether the grant is real or local. This lets the failing response be classified as a load fault or a store fault, even if the master has already moved its write flag on to the next access. Only one transaction is outstanding at a time. The master must hold its address, and the checker must hold its verdict, until the grant is seen. The master must not raise a new request until the response has arrived.

Top module: `fault_gated_req_port`

## Requirements
- R1: The bus request output equals the master request ANDed with the inverse of the fault input, combinationally. The bus address and write flag follow the master's values in the same cycle.
- R2: If a request is presented with the fault input high in cycle k, the master receives a locally produced grant in cycle k+1 and never in cycle k, without any bus grant.
- R3: While idle, a bus grant reaches the master grant output in the same cycle. After any grant, the block waits for a response, and the master grant output stays low until that response has been delivered.
- R4: In the cycle after a locally produced grant, the master sees a response valid with the error bit set, with no bus response needed.
- R5: For a transaction the bus granted, the master's response valid and error follow the bus response valid and error. The master error is never high without the master response valid.
- R6: The write flag is captured at the grant. A failing response raises the load-fault output if the captured flag was 0, and the store-fault output if it was 1. Changes to the master write flag after the grant have no effect on this choice.
- R7: Each failing transaction raises exactly one of load-fault or store-fault, for exactly one cycle.
- R8: After reset, the block is idle and the registered fault is clear. A fault seen while reset is asserted produces no grant and no response.
- R9: A bus response valid that arrives while the block is idle is ignored, and the master response valid stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| m_req_i | input | 1 | Master request |
| m_addr_i | input | ADDR_W | Master address |
| m_we_i | input | 1 | Master write flag (1 = store) |
| m_gnt_o | output | 1 | Grant to master (real or local) |
| m_rvalid_o | output | 1 | Response valid to master |
| m_err_o | output | 1 | Response error to master |
| load_fault_o | output | 1 | One-cycle pulse: failing load response |
| store_fault_o | output | 1 | One-cycle pulse: failing store response |
| fault_i | input | 1 | Access fault verdict for the current master address |
| b_req_o | output | 1 | Bus request |
| b_addr_o | output | ADDR_W | Bus address |
| b_we_o | output | 1 | Bus write flag |
| b_gnt_i | input | 1 | Bus grant |
| b_rvalid_i | input | 1 | Bus response valid |
| b_err_i | input | 1 | Bus response error |

## Verification
Some results are due in the same cycle as their stimulus: the bus request gating, the address passthrough and a real grant. These are sampled at the falling edge of the cycle that drives them. A local grant is due exactly one rising edge after the faulted request is presented. The faked response is due one edge after that. A real response is due in the same cycle as the bus response valid. The bench drives all inputs just after a rising edge. It counts edges per transaction and samples each output mid-cycle, in the cycle where it is due, and also in the cycles before and after, where it must be low.

// File: rtl/fgate_pkg.sv
// Shared types for the fault-gated request port.
package fgate_pkg;

    // Transaction controller state
    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,  // accepting a request
        ST_RESP = 1'b1   // granted, waiting for a response
    } txn_state_e;

    // Attributes captured at grant time
    typedef struct packed {
        logic is_store;  // 1: store access, 0: load access
        logic faulted;   // grant was produced from a protection fault
    } txn_attr_t;

endpackage

// File: rtl/fgate_fault_reg.sv
// Fault sampling register.
// Registers the checker's verdict, qualified by the master request, so that
// the local grant is produced from a stable, flopped copy. Assumes the
// master holds its address (and the checker its verdict) until granted.
module fgate_fault_reg (
    input  logic clk,
    input  logic rst_n,
    input  logic req_i,
    input  logic fault_i,
    output logic fault_q_o
);

    // Capture the request-qualified fault each cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) fault_q_o <= 1'b0;
        else        fault_q_o <= req_i & fault_i;
    end

endmodule

// File: rtl/fgate_txn_ctrl.sv
// Transaction controller.
// Tracks a single outstanding access. While idle it passes a real grant
// through, or it grants locally from the registered fault. In the response
// state it completes on a bus response, or at once if the grant was local.
// Assumes the master raises no new request before the response arrives.
module fgate_txn_ctrl
    import fgate_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      m_req_i,
    input  logic      m_we_i,
    input  logic      fault_q_i,
    input  logic      b_gnt_i,
    input  logic      b_rvalid_i,
    input  logic      b_err_i,
    output logic      m_gnt_o,
    output logic      m_rvalid_o,
    output logic      m_err_o,
    output txn_attr_t attr_o
);

    txn_state_e state_q, state_d;
    txn_attr_t  attr_q, attr_d;
    logic       grant;

    // Grant is real or local, and only taken while idle.
    always_comb begin
        grant = 1'b0;
        if (state_q == ST_IDLE) grant = m_req_i & (b_gnt_i | fault_q_i);
    end

    // Next state and captured attributes.
    always_comb begin
        state_d = state_q;
        attr_d  = attr_q;
        unique case (state_q)
            ST_IDLE: begin
                if (grant) begin
                    state_d         = ST_RESP;
                    attr_d.is_store = m_we_i;
                    attr_d.faulted  = fault_q_i;
                end
            end
            ST_RESP: begin
                if (b_rvalid_i || attr_q.faulted) begin
                    state_d        = ST_IDLE;
                    attr_d.faulted = 1'b0;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State and attribute registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            attr_q  <= '0;
        end else begin
            state_q <= state_d;
            attr_q  <= attr_d;
        end
    end

    // Master-side response; a local completion carries an error.
    always_comb begin
        m_gnt_o    = grant;
        m_rvalid_o = 1'b0;
        m_err_o    = 1'b0;
        if (state_q == ST_RESP) begin
            m_rvalid_o = b_rvalid_i | attr_q.faulted;
            m_err_o    = (b_rvalid_i & b_err_i) | attr_q.faulted;
        end
    end

    assign attr_o = attr_q;

    AST_GNT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        m_gnt_o |=> !m_gnt_o); // R3
    AST_ERR_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        m_err_o |-> m_rvalid_o); // R5
    AST_IDLE_RESP_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (!m_gnt_o && state_q == ST_IDLE) |=> !m_rvalid_o); // R9

endmodule

// File: rtl/fgate_err_class.sv
// Error classifier.
// Splits a failing response into a load-fault or store-fault pulse, using
// the write flag captured at grant time.
module fgate_err_class
    import fgate_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      rvalid_i,
    input  logic      err_i,
    input  txn_attr_t attr_i,
    output logic      load_fault_o,
    output logic      store_fault_o
);

    logic fail;

    // A failing response is a valid response carrying an error.
    always_comb begin
        fail          = rvalid_i & err_i;
        load_fault_o  = fail & ~attr_i.is_store;
        store_fault_o = fail &  attr_i.is_store;
    end

    AST_FAULT_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(load_fault_o && store_fault_o)); // R6
    AST_LOAD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        load_fault_o |=> !load_fault_o); // R7
    AST_STORE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        store_fault_o |=> !store_fault_o); // R7

endmodule

// File: rtl/fault_gated_req_port.sv
// Fault-gated bus request port (top).
// Keeps faulted requests off the bus and completes them toward the master
// as a local grant followed by an error response. Assumes one outstanding
// access, and that the address and fault verdict stay stable until granted.
module fault_gated_req_port
    import fgate_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              m_req_i,
    input  logic [ADDR_W-1:0] m_addr_i,
    input  logic              m_we_i,
    output logic              m_gnt_o,
    output logic              m_rvalid_o,
    output logic              m_err_o,
    output logic              load_fault_o,
    output logic              store_fault_o,
    input  logic              fault_i,
    output logic              b_req_o,
    output logic [ADDR_W-1:0] b_addr_o,
    output logic              b_we_o,
    input  logic              b_gnt_i,
    input  logic              b_rvalid_i,
    input  logic              b_err_i
);

    logic      fault_q;
    txn_attr_t attr;

    // Bus-side request gating and attribute passthrough.
    always_comb begin
        b_req_o  = m_req_i & ~fault_i;
        b_addr_o = m_addr_i;
        b_we_o   = m_we_i;
    end

    fgate_fault_reg u_fault_reg (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_i     (m_req_i),
        .fault_i   (fault_i),
        .fault_q_o (fault_q)
    );

    fgate_txn_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .m_req_i    (m_req_i),
        .m_we_i     (m_we_i),
        .fault_q_i  (fault_q),
        .b_gnt_i    (b_gnt_i),
        .b_rvalid_i (b_rvalid_i),
        .b_err_i    (b_err_i),
        .m_gnt_o    (m_gnt_o),
        .m_rvalid_o (m_rvalid_o),
        .m_err_o    (m_err_o),
        .attr_o     (attr)
    );

    fgate_err_class u_class (
        .clk           (clk),
        .rst_n         (rst_n),
        .rvalid_i      (m_rvalid_o),
        .err_i         (m_err_o),
        .attr_i        (attr),
        .load_fault_o  (load_fault_o),
        .store_fault_o (store_fault_o)
    );

    AST_FAULT_OFF_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        (m_gnt_o && !b_gnt_i) |-> !b_req_o); // R1
    AST_LOCAL_GNT_DELAYED: assert property (@(posedge clk) disable iff (!rst_n)
        (m_gnt_o && !b_gnt_i) |-> $past(m_req_i && fault_i)); // R2
    AST_LOCAL_GNT_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (m_gnt_o && !b_gnt_i) |=> (m_rvalid_o && m_err_o)); // R4

endmodule

// File: tb/fault_gated_req_port_test.sv
`timescale 1ns/1ps
module fault_gated_req_port_test;

    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          m_req = 1'b0, m_we = 1'b0, fault = 1'b0;
    logic [AW-1:0] m_addr = '0;
    logic          b_gnt = 1'b0, b_rvalid = 1'b0, b_err = 1'b0;
    logic          m_gnt, m_rvalid, m_err, ld_f, st_f, b_req, b_we;
    logic [AW-1:0] b_addr;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;  // 250 MHz

    fault_gated_req_port #(.ADDR_W(AW)) uut (
        .clk(clk), .rst_n(rst_n),
        .m_req_i(m_req), .m_addr_i(m_addr), .m_we_i(m_we),
        .m_gnt_o(m_gnt), .m_rvalid_o(m_rvalid), .m_err_o(m_err),
        .load_fault_o(ld_f), .store_fault_o(st_f),
        .fault_i(fault),
        .b_req_o(b_req), .b_addr_o(b_addr), .b_we_o(b_we),
        .b_gnt_i(b_gnt), .b_rvalid_i(b_rvalid), .b_err_i(b_err)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0b expected %0b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic chkv(input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    // Advance to just after the next rising edge (drive point).
    task automatic step();
        @(posedge clk); #1;
    endtask

    // Wait to the falling edge (sample point).
    task automatic mid();
        @(negedge clk);
    endtask

    task automatic quiet_resp(input string req);
        chk(req, m_rvalid, 1'b0);
        chk(req, m_err, 1'b0);
        chk(req, ld_f, 1'b0);
        chk(req, st_f, 1'b0);
    endtask

    // One transaction: f = fault, w = write, e = bus error,
    // gd = grant delay, rd = response delay (>=1).
    task automatic run_txn(input logic f, input logic w, input logic e,
                           input int gd, input int rd, input logic [AW-1:0] a);
        step();
        m_req = 1'b1; m_we = w; m_addr = a; fault = f;
        if (f) begin
            mid();
            chk("R1 gated req", b_req, 1'b0);
            chkv("R1 addr pass", b_addr, a);
            chk("R1 we pass", b_we, w);
            chk("R2 no same-cycle grant", m_gnt, 1'b0);
            step();
            mid();
            chk("R2 local grant", m_gnt, 1'b1);
            chk("R1 still gated", b_req, 1'b0);
            step();
            m_req = 1'b0; fault = 1'b0; m_we = ~w;
            mid();
            chk("R3 no grant in wait", m_gnt, 1'b0);
            chk("R4 faked rvalid", m_rvalid, 1'b1);
            chk("R4 faked err", m_err, 1'b1);
            chk("R6 load fault", ld_f, ~w);
            chk("R6 store fault", st_f, w);
            step();
            mid();
            quiet_resp("R7 single pulse");
        end else begin
            for (int i = 0; i < gd; i++) begin
                mid();
                chk("R1 req passes", b_req, 1'b1);
                chk("R3 no grant yet", m_gnt, 1'b0);
                step();
            end
            b_gnt = 1'b1;
            mid();
            chkv("R1 addr pass", b_addr, a);
            chk("R3 grant passthrough", m_gnt, 1'b1);
            step();
            b_gnt = 1'b0; m_req = 1'b0; m_we = ~w;
            for (int i = 1; i < rd; i++) begin
                mid();
                chk("R3 no grant in wait", m_gnt, 1'b0);
                quiet_resp("R5 no early resp");
                step();
            end
            b_rvalid = 1'b1; b_err = e;
            mid();
            chk("R5 rvalid follows", m_rvalid, 1'b1);
            chk("R5 err follows", m_err, e);
            chk("R6 load fault", ld_f, e & ~w);
            chk("R6 store fault", st_f, e & w);
            step();
            b_rvalid = 1'b0; b_err = 1'b0;
            mid();
            quiet_resp("R7 single pulse");
        end
    endtask

    initial begin
        #400000;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        // R8: fault and request while in reset
        m_req = 1'b1; fault = 1'b1;
        repeat (3) @(posedge clk);
        mid();
        chk("R8 no grant in reset", m_gnt, 1'b0);
        chk("R8 no resp in reset", m_rvalid, 1'b0);
        step();
        rst_n = 1'b1; m_req = 1'b0; fault = 1'b0;
        mid();
        chk("R8 idle grant", m_gnt, 1'b0);
        quiet_resp("R8 idle resp");
        // R9: stray bus response while idle
        step();
        b_rvalid = 1'b1; b_err = 1'b1;
        mid();
        quiet_resp("R9 idle rvalid ignored");
        step();
        b_rvalid = 1'b0; b_err = 1'b0;
        // Sweep
        for (int f = 0; f < 2; f++)
            for (int w = 0; w < 2; w++)
                for (int e = 0; e < 2; e++)
                    for (int gd = 0; gd < 4; gd++)
                        for (int rd = 1; rd < 4; rd++)
                            run_txn(f[0], w[0], e[0], gd, rd,
                                    32'h1000_0000 + 32'(f*64 + w*32 + e*16 + gd*4 + rd));
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule